// File: doc/BRIEF.md
# Maskable Alarm Interrupt Controller

This block collects six alarm conditions into a single active-high interrupt line. The six sources are: calibration running, non-volatile load error, non-volatile save error, PLL lock lost, reference input signal lost, and feedback input signal lost. The detectors for these conditions live elsewhere. Their outputs reach this block as level signals that are already synchronous to its clock.

Each source has three bits:
- a live status bit that follows the condition, read-only;
- an event-capturing bit that stays set until software clears it;
- a mask bit that keeps the source off the interrupt line.

A loss of either input signal always counts as a loss of lock, before anything is stored or combined. Software reaches the three bit sets through a small address/data register port. Reads of this port are combinational.

Top module: `alarm_irq_top`

## Requirements
- R1: After reset, the captured bits and the mask bits read as zero, and `irqOut` is 0.
- R2: Address 0 returns the live status in the same cycle, with the bit order calibration=0, load error=1, save error=2, lock lost=3, reference signal lost=4, feedback signal lost=5. A live bit clears as soon as its input drops, and it shows its input whatever its mask bit holds.
- R3: When `alarmIn[4]` or `alarmIn[5]` is high, live bit 3 (lock lost) reads 1 even when `alarmIn[3]` is low.
- R4: A live bit that is high at a clock edge sets the matching captured bit at that edge. Captured bits are read at address 1, and they stay set after the live bit drops.
- R5: A write to address 1 clears each captured bit whose data bit is 1. Captured bits whose data bit is 0 are left unchanged.
- R6: If a clear and an active live bit meet at the same edge, the captured bit stays set.
- R7: Address 2 holds the six mask bits. They are written by a write to that address and read back unchanged.
- R8: `irqOut` is registered. After each edge it equals the OR of the live bits whose mask bit is 0, as they were before that edge.
- R9: Writes to address 0 and to address 3 change nothing. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Active-low reset, synchronous |
| alarmIn | input | 6 | Alarm conditions, one per source, level |
| regAddr | input | 2 | Register select: 0 live, 1 captured, 2 mask, 3 unused |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | 6 | Write data |
| regRdData | output | 6 | Read data of the selected register, same cycle |
| irqOut | output | 1 | Interrupt, active high |

## Verification
The following rules are checked on every cycle against the live signals:
- signal loss forcing the lock-lost bit;
- captured bits latching whatever was live at an edge, including when a clear arrives at that same edge;
- captured bits never clearing without a write to their address;
- mask loads landing one edge after the write;
- the interrupt rising when nothing is masked and some alarm is present.

Only the bench scenarios show the following:
- the exact bit order;
- live bits clearing while masked;
- write-one-to-clear touching only the selected bits;
- masking actually silencing the line, including the lock bit that signal loss drags along;
- writes to the live and unused addresses being harmless.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int NUM_SRC = 6;
  localparam int ADDR_W  = 2;

  localparam int SRC_CAL    = 0;
  localparam int SRC_LOAD   = 1;
  localparam int SRC_SAVE   = 2;
  localparam int SRC_LOCK   = 3;
  localparam int SRC_REFLOS = 4;
  localparam int SRC_FBLOS  = 5;

  typedef enum logic [ADDR_W-1:0] {
    REG_LIVE   = 2'd0,
    REG_STICKY = 2'd1,
    REG_MASK   = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic               maskLoad;
    logic               stickyClear;
    logic [NUM_SRC-1:0] wrBits;
  } dp_strobe_t;
endpackage

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
(
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [NUM_SRC-1:0] regWrData,
  input  logic [NUM_SRC-1:0] liveBits,
  input  logic [NUM_SRC-1:0] stickyBits,
  input  logic [NUM_SRC-1:0] maskBits,
  output dp_strobe_t         strobe,
  output logic [NUM_SRC-1:0] regRdData
);
  reg_sel_e sel;

  assign sel = reg_sel_e'(regAddr);

  // write decode into datapath strobes
  always_comb begin
    strobe             = '0;
    strobe.wrBits      = regWrData;
    strobe.maskLoad    = regWrEn && (sel == REG_MASK);
    strobe.stickyClear = regWrEn && (sel == REG_STICKY);
  end

  // combinational read select
  always_comb begin
    case (sel)
      REG_LIVE:   regRdData = liveBits;
      REG_STICKY: regRdData = stickyBits;
      REG_MASK:   regRdData = maskBits;
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/alarm_irq_dp.sv
module alarm_irq_dp
  import alarm_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] alarmIn,
  input  dp_strobe_t         strobe,
  output logic [NUM_SRC-1:0] liveBits,
  output logic [NUM_SRC-1:0] stickyBits,
  output logic [NUM_SRC-1:0] maskBits,
  output logic               irqOut
);
  // signal loss on either input folds into lock lost
  always_comb begin
    liveBits           = alarmIn;
    liveBits[SRC_LOCK] = alarmIn[SRC_LOCK] | alarmIn[SRC_REFLOS] | alarmIn[SRC_FBLOS];
  end

  // one capture flop per source; a live event outranks a clear
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (!rstN)                                  stickyBits[i] <= 1'b0;
      else if (liveBits[i])                       stickyBits[i] <= 1'b1;
      else if (strobe.stickyClear && strobe.wrBits[i]) stickyBits[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                maskBits <= '0;
    else if (strobe.maskLoad) maskBits <= strobe.wrBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |(liveBits & ~maskBits);
  end
endmodule

// File: rtl/alarm_irq_top.sv
module alarm_irq_top
  import alarm_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] alarmIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [NUM_SRC-1:0] regWrData,
  output logic [NUM_SRC-1:0] regRdData,
  output logic               irqOut
);
  dp_strobe_t         strobe;
  logic [NUM_SRC-1:0] liveBits;
  logic [NUM_SRC-1:0] stickyBits;
  logic [NUM_SRC-1:0] maskBits;

  alarm_irq_ctrl ctrl_i (
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .liveBits  (liveBits),
    .stickyBits(stickyBits),
    .maskBits  (maskBits),
    .strobe    (strobe),
    .regRdData (regRdData)
  );

  alarm_irq_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .alarmIn   (alarmIn),
    .strobe    (strobe),
    .liveBits  (liveBits),
    .stickyBits(stickyBits),
    .maskBits  (maskBits),
    .irqOut    (irqOut)
  );
endmodule

// File: rtl/alarm_irq_chk.sv
module alarm_irq_chk
  import alarm_irq_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] alarmIn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWrEn,
  input logic [NUM_SRC-1:0] regWrData,
  input logic [NUM_SRC-1:0] regRdData,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] liveBits,
  input logic [NUM_SRC-1:0] stickyBits,
  input logic [NUM_SRC-1:0] maskBits
);
  // R3
  lol_from_los_chk: assert property (@(posedge clk) disable iff (!rstN)
    (alarmIn[SRC_REFLOS] || alarmIn[SRC_FBLOS]) |-> liveBits[SRC_LOCK]);

  // R2
  live_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == REG_LIVE && alarmIn[SRC_CAL]) |-> regRdData[SRC_CAL]);

  // R4
  sticky_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (liveBits != '0) |=> ((stickyBits & $past(liveBits)) == $past(liveBits)));

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == REG_STICKY) |=> ((stickyBits & $past(stickyBits)) == $past(stickyBits)));

  // R6
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == REG_STICKY && (alarmIn & regWrData) != '0)
      |=> ((stickyBits & $past(alarmIn & regWrData)) == $past(alarmIn & regWrData)));

  // R7
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == REG_MASK) |=> (maskBits == $past(regWrData)));

  // R8
  irq_unmasked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskBits == '0 && alarmIn != '0) |=> irqOut);

  // R9
  unused_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == REG_NONE) |-> (regRdData == '0));
endmodule

bind alarm_irq_top alarm_irq_chk chk_i (.*);

// File: tb/alarm_irq_top_tb_top.sv
module alarm_irq_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] alarmIn = '0;
  logic [1:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [5:0] regWrData = '0;
  logic [5:0] regRdData;
  logic       irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  alarm_irq_top dut_i (
    .clk(clk), .rstN(rstN), .alarmIn(alarmIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [5:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic setAlarm(input logic [5:0] a);
    @(negedge clk);
    alarmIn = a;
    #1;
  endtask

  task automatic cleanSlate();
    setAlarm(6'b0);
    wr(2'd2, 6'b0);
    wr(2'd1, 6'h3F);
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [5:0] v;
    check("R1 irq", {5'b0, irqOut}, 6'b0);
    rd(2'd1, v); check("R1 sticky", v, 6'b0);
    rd(2'd2, v); check("R1 mask", v, 6'b0);
  endtask

  task automatic testLive();
    logic [5:0] v;
    cleanSlate();
    setAlarm(6'b000001);
    rd(2'd0, v); check("R2 cal bit0", v, 6'b000001);
    setAlarm(6'b000110);
    rd(2'd0, v); check("R2 load/save bits", v, 6'b000110);
    wr(2'd2, 6'h3F);
    setAlarm(6'b000100);
    rd(2'd0, v); check("R2 masked still live", v, 6'b000100);
    setAlarm(6'b0);
    rd(2'd0, v); check("R2 self clear", v, 6'b0);
  endtask

  task automatic testLosLol();
    logic [5:0] v;
    cleanSlate();
    setAlarm(6'b010000);
    rd(2'd0, v); check("R3 ref loss", v, 6'b011000);
    setAlarm(6'b100000);
    rd(2'd0, v); check("R3 fb loss", v, 6'b101000);
  endtask

  task automatic testSticky();
    logic [5:0] v;
    cleanSlate();
    setAlarm(6'b000010);
    setAlarm(6'b0);
    rd(2'd1, v); check("R4 sticky after pulse", v, 6'b000010);
    setAlarm(6'b000100);
    setAlarm(6'b0);
    rd(2'd1, v); check("R4 sticky accumulates", v, 6'b000110);
    wr(2'd1, 6'b000100);
    rd(2'd1, v); check("R5 partial clear", v, 6'b000010);
    wr(2'd1, 6'b000010);
    rd(2'd1, v); check("R5 full clear", v, 6'b0);
  endtask

  task automatic testClearRace();
    logic [5:0] v;
    cleanSlate();
    setAlarm(6'b000100);
    wr(2'd1, 6'b000100);
    setAlarm(6'b0);
    rd(2'd1, v); check("R6 event beats clear", v, 6'b000100);
  endtask

  task automatic testMask();
    logic [5:0] v;
    cleanSlate();
    wr(2'd2, 6'b101010);
    rd(2'd2, v); check("R7 mask readback", v, 6'b101010);
    wr(2'd2, 6'b010101);
    rd(2'd2, v); check("R7 mask rewrite", v, 6'b010101);
  endtask

  task automatic testIrq();
    cleanSlate();
    check("R8 irq idle", {5'b0, irqOut}, 6'b0);
    @(negedge clk);
    alarmIn = 6'b000001;
    #1;
    check("R8 irq not before edge", {5'b0, irqOut}, 6'b0);
    @(negedge clk);
    check("R8 irq after edge", {5'b0, irqOut}, 6'b1);
    wr(2'd2, 6'b000001);
    @(negedge clk);
    check("R8 irq masked", {5'b0, irqOut}, 6'b0);
    wr(2'd2, 6'b100001);
    setAlarm(6'b100000);
    @(negedge clk);
    check("R8 lock bit from fb loss unmasked", {5'b0, irqOut}, 6'b1);
    wr(2'd2, 6'b101001);
    @(negedge clk);
    check("R8 fully masked", {5'b0, irqOut}, 6'b0);
  endtask

  task automatic testIgnored();
    logic [5:0] v;
    cleanSlate();
    wr(2'd2, 6'b001100);
    setAlarm(6'b000001);
    setAlarm(6'b0);
    wr(2'd0, 6'h3F);
    rd(2'd0, v); check("R9 live write ignored", v, 6'b0);
    rd(2'd2, v); check("R9 mask untouched by addr0", v, 6'b001100);
    wr(2'd3, 6'h3F);
    rd(2'd3, v); check("R9 addr3 reads zero", v, 6'b0);
    rd(2'd1, v); check("R9 sticky untouched", v, 6'b000001);
    rd(2'd2, v); check("R9 mask untouched by addr3", v, 6'b001100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    testReset();
    testLive();
    testLosLol();
    testSticky();
    testClearRace();
    testMask();
    testIrq();
    testIgnored();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule